// File: doc/BRIEF.md
# Self-timed write cycle and programming guard

This controller sits beside the serial protocol engine of a small nonvolatile memory slave. When the protocol engine sees a valid STOP that closes a byte or page write, it sends a one-cycle commit pulse. The controller then decides whether programming is allowed. Programming needs the protect pin high and the low-supply flag clear. If it is allowed, the controller holds a busy state for a fixed number of clock cycles, which stands in for the nonvolatile write time.

While busy, every acknowledge that the protocol engine asks for is suppressed, including the one for its own device address. A bus controller can therefore poll with START plus device address until it receives an ACK. The protect pin is looked at only at the moment of commit, so a later change on it does not touch a cycle that is already running. A low-supply indication during a cycle aborts that cycle, and the committed data is then never written.

A commit that is blocked still lets the bus transfer finish normally, but no cycle starts and a reject pulse is raised. A done pulse marks the end of a completed cycle, and the memory array uses that pulse to take the data.

Top module: `eeprom_wcycle_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, reject_o and abort_o are all 0.
- R2: A commit_i pulse sampled while idle, with wp_allow_i = 1 (1 means writes allowed) and low_supply_i = 0, makes busy_o 1 from the next cycle on, for exactly WR_CYCLES consecutive cycles.
- R3: done_o is a one-cycle pulse in the first cycle in which busy_o is 0 again after a completed cycle.
- R4: ack_o equals ack_req_i while busy_o is 0 and is 0 in every cycle in which busy_o is 1.
- R5: A commit_i sampled while idle with wp_allow_i = 0 starts no cycle, and reject_o is 1 for exactly the next cycle.
- R6: A commit_i sampled while idle with low_supply_i = 1 starts no cycle, and reject_o is 1 for exactly the next cycle.
- R7: Changes of wp_allow_i after an accepted commit change neither the cycle length nor the done_o pulse.
- R8: If low_supply_i is sampled 1 while busy_o is 1, then in the next cycle busy_o is 0 and abort_o is 1 for one cycle, and done_o stays 0 for that cycle.
- R9: A commit_i sampled while busy_o is 1 is ignored. The running cycle ends at its original time and reject_o stays 0.
- R10: ro_o (memory read-only status) is 1 exactly when wp_allow_i is 0 or low_supply_i is 1, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit_i | input | 1 | One-cycle pulse from the protocol engine at a valid STOP ending a write |
| wp_allow_i | input | 1 | Protect pin level; 1 allows programming |
| low_supply_i | input | 1 | Low-supply indication |
| ack_req_i | input | 1 | Acknowledge requested by the protocol engine |
| ack_o | output | 1 | Acknowledge after busy gating |
| busy_o | output | 1 | Self-timed write cycle in progress |
| done_o | output | 1 | Pulse: cycle completed, data to be written |
| reject_o | output | 1 | Pulse: commit refused by the protect pin or low supply |
| abort_o | output | 1 | Pulse: running cycle cancelled by low supply |
| ro_o | output | 1 | Memory currently read-only |

## Verification
The three pulses (reject_o, abort_o and done_o) and busy_o are registered. Each of them therefore changes on the first clock edge after the input that causes it, and the bench samples them one time unit after that edge. The done_o pulse is due WR_CYCLES edges after the commit edge, so the bench counts the busy_o cycles itself and then checks done_o in the first idle cycle. ack_o and ro_o are combinational, and the bench checks them in the same cycle as the inputs that set them. The bench sweeps every point at which an abort or an ignored commit can fall inside a cycle, and all four combinations of protect pin and supply at commit.

// File: rtl/wc_pkg.sv
package wc_pkg;
  // Commit is accepted only when idle and all programming guards are open.
  function automatic logic wc_accept(input logic commit, input logic allow,
                                     input logic low, input logic busy);
    return commit && !busy && allow && !low;
  endfunction

  // Commit arrives when idle but a guard refuses it.
  function automatic logic wc_refuse(input logic commit, input logic allow,
                                     input logic low, input logic busy);
    return commit && !busy && (!allow || low);
  endfunction

  // Read-only status from the current guard levels.
  function automatic logic wc_readonly(input logic allow, input logic low);
    return !allow || low;
  endfunction
endpackage

// File: rtl/wc_guard.sv
module wc_guard (
  input  logic commit_i,
  input  logic allow_i,
  input  logic low_i,
  input  logic busy_i,
  output logic accept_o,
  output logic refuse_o,
  output logic ro_o
);
  import wc_pkg::*;
  always_comb begin
    accept_o = wc_accept(commit_i, allow_i, low_i, busy_i);
    refuse_o = wc_refuse(commit_i, allow_i, low_i, busy_i);
    ro_o     = wc_readonly(allow_i, low_i);
  end
endmodule

// File: rtl/wc_timer.sv
module wc_timer #(
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic kill_i,
  output logic busy_o,
  output logic finish_o,
  output logic cancel_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          last_cycle;

  assign busy_o     = (cnt_q != '0);
  assign last_cycle = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      finish_o <= 1'b0;
      cancel_o <= 1'b0;
    end else begin
      finish_o <= 1'b0;
      cancel_o <= 1'b0;
      if (busy_o && kill_i) begin
        cnt_q    <= '0;
        cancel_o <= 1'b1;
      end else if (busy_o) begin
        cnt_q    <= cnt_q - CW'(1);
        finish_o <= last_cycle;
      end else if (start_i) begin
        cnt_q <= LOAD;
      end
    end
  end
endmodule

// File: rtl/wc_ack_gate.sv
module wc_ack_gate (
  input  logic req_i,
  input  logic busy_i,
  output logic ack_o
);
  assign ack_o = req_i && !busy_i;
endmodule

// File: rtl/eeprom_wcycle_ctrl.sv
module eeprom_wcycle_ctrl #(
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic wp_allow_i,
  input  logic low_supply_i,
  input  logic ack_req_i,
  output logic ack_o,
  output logic busy_o,
  output logic done_o,
  output logic reject_o,
  output logic abort_o,
  output logic ro_o
);
  // Named internal events, visible to the bound checker.
  logic accept_ev;
  logic refuse_ev;
  logic reject_q;

  wc_guard u_guard (
    .commit_i (commit_i),
    .allow_i  (wp_allow_i),
    .low_i    (low_supply_i),
    .busy_i   (busy_o),
    .accept_o (accept_ev),
    .refuse_o (refuse_ev),
    .ro_o     (ro_o)
  );

  wc_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept_ev),
    .kill_i   (low_supply_i),
    .busy_o   (busy_o),
    .finish_o (done_o),
    .cancel_o (abort_o)
  );

  wc_ack_gate u_ack (
    .req_i  (ack_req_i),
    .busy_i (busy_o),
    .ack_o  (ack_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reject_q <= 1'b0;
    else        reject_q <= refuse_ev;
  end
  assign reject_o = reject_q;
endmodule

// File: rtl/eeprom_wcycle_chk.sv
module eeprom_wcycle_chk (
  input logic clk,
  input logic rst_n,
  input logic commit_i,
  input logic wp_allow_i,
  input logic low_supply_i,
  input logic ack_req_i,
  input logic ack_o,
  input logic busy_o,
  input logic done_o,
  input logic reject_o,
  input logic abort_o,
  input logic ro_o
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy_o && wp_allow_i && !low_supply_i) |=> busy_o);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_no_ack_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ack_o);
  p_ack_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (ack_o == ack_req_i));
  p_protect_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy_o && !wp_allow_i) |=> (reject_o && !busy_o));
  p_supply_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy_o && low_supply_i) |=> (reject_o && !busy_o));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && low_supply_i) |=> (!busy_o && abort_o && !done_o));
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && commit_i) |=> !reject_o);
  p_readonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ro_o == (!wp_allow_i || low_supply_i));
endmodule

bind eeprom_wcycle_ctrl eeprom_wcycle_chk u_chk (.*);

// File: tb/test_eeprom_wcycle_ctrl.sv
module test_eeprom_wcycle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic commit_i = 1'b0, wp_allow_i = 1'b1, low_supply_i = 1'b0, ack_req_i = 1'b0;
  logic ack_o, busy_o, done_o, reject_o, abort_o, ro_o;
  int vectors = 0;
  int errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wcycle_ctrl #(.WR_CYCLES(WR)) i_eeprom_wcycle_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Issue an accepted commit; returns after the commit edge with busy expected.
  task automatic commit_ok();
    wp_allow_i = 1'b1; low_supply_i = 1'b0; commit_i = 1'b1;
    step();
    commit_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    chk("R1 reject", reject_o, 0); chk("R1 abort", abort_o, 0);
    rst_n = 1'b1;
    step();

    // R10 and R4 (idle): sweep all guard and request combinations
    for (int c = 0; c < 8; c++) begin
      wp_allow_i = c[0]; low_supply_i = c[1]; ack_req_i = c[2];
      #1;
      chk("R10 ro", ro_o, (!c[0] || c[1]) ? 1 : 0);
      chk("R4 idle ack", ack_o, c[2] ? 1 : 0);
    end
    wp_allow_i = 1'b1; low_supply_i = 1'b0; ack_req_i = 1'b0;
    step();

    // R5/R6/R2: all four guard combinations at commit
    for (int c = 0; c < 4; c++) begin
      wp_allow_i = c[0]; low_supply_i = c[1]; commit_i = 1'b1;
      step();
      commit_i = 1'b0; low_supply_i = 1'b0; wp_allow_i = 1'b1;
      if (c == 1) begin
        n = 0;
        while (busy_o && n < 100) begin ack_req_i = 1'b1; #1;
          chk("R4 busy ack", ack_o, 0); ack_req_i = 1'b0; n++; step(); end
        chk("R2 length", n, WR);
        chk("R3 done", done_o, 1);
        step();
        chk("R3 done one cycle", done_o, 0);
      end else begin
        chk(c[1] ? "R6 no busy" : "R5 no busy", busy_o, 0);
        chk(c[1] ? "R6 reject" : "R5 reject", reject_o, 1);
        step();
        chk("R5 reject one cycle", reject_o, 0);
        chk("R5 done never", done_o, 0);
      end
    end

    // R7: drop protect at every point of a cycle
    for (int k = 0; k < WR; k++) begin
      commit_ok();
      n = 0;
      while (busy_o && n < 100) begin
        wp_allow_i = (n < k) ? 1'b1 : 1'b0;
        n++; step();
      end
      chk("R7 length", n, WR);
      chk("R7 done", done_o, 1);
      wp_allow_i = 1'b1;
      step();
    end

    // R8: low supply at every point within a cycle
    for (int k = 1; k <= WR; k++) begin
      commit_ok();
      for (int j = 1; j < k; j++) step();
      chk("R8 still busy", busy_o, 1);
      low_supply_i = 1'b1;
      step();
      low_supply_i = 1'b0;
      chk("R8 busy cleared", busy_o, 0);
      chk("R8 abort", abort_o, 1);
      chk("R8 no done", done_o, 0);
      n = 0;
      for (int j = 0; j < WR + 2; j++) begin step(); n += done_o + abort_o + busy_o; end
      chk("R8 quiet after abort", n, 0);
    end

    // R9: extra commit at every busy cycle
    for (int k = 1; k <= WR; k++) begin
      commit_ok();
      n = 1;
      for (int j = 1; j < k; j++) begin step(); n++; end
      commit_i = 1'b1; step(); commit_i = 1'b0;
      chk("R9 no reject", reject_o, 0);
      while (busy_o && n < 100) begin n++; step(); end
      chk("R9 original end", n, WR);
      chk("R9 done", done_o, 1);
      for (int j = 0; j < 2; j++) step();
      chk("R9 no restart", busy_o, 0);
    end

    finish_run();
  end
endmodule